// File: doc/BRIEF.md
# Local Interrupt Pending Selector

This block keeps the machine-level interrupt-pending bits of a hart and decides which local interrupt the hart should take. Sources change pending bits through a masked-update port. Each update returns the bits as they were before the change. A claim port lets an interrupt source reserve a set of pending bits for itself. The claim fails when another source already owns any of those bits.

Selection runs combinationally from the registered pending and enable bits. It also uses the delegation mask, the current privilege and the two global enable bits. A bit that is not delegated goes to machine level. A delegated bit goes to supervisor level. Either kind counts only when the hart runs below that level, or at that level with the matching global enable set. Among the bits that count, the lowest index wins.

The update and claim ports are strobe-and-response streams. The block never applies back-pressure. A request presented with its valid strobe is always accepted at that clock edge. Its response is valid for exactly one cycle after that edge, so no ready signal is needed.

Top module: `irq_select_unit`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the pending bits, the enable bits, the claim bits and the request flag. Afterwards take_o is 0 and both response strobes are 0.
- R2: An update with upd_valid_i high loads each pending bit whose upd_mask_i bit is 1 from upd_value_i. Every other pending bit keeps its value. The change is visible after that clock edge.
- R3: One cycle after an accepted update, upd_done_o is 1 for that one cycle and upd_old_o holds the pending bits as they were before the update.
- R4: After each update, hard_req_o is 1 if the new pending value is nonzero and 0 if it is zero. Enable writes and claims leave hard_req_o unchanged.
- R5: Only bits set in both the pending register and the enable register are candidates. A bit that is pending but not enabled is never selected.
- R6: A candidate whose deleg_i bit is 0 counts when priv_i is below machine, or when priv_i is machine and m_gie_i is 1. Privilege encoding: 2'b00 user, 2'b01 supervisor, 2'b10 reserved (ranked above supervisor and below machine), 2'b11 machine.
- R7: A candidate whose deleg_i bit is 1 counts when priv_i is user, or when priv_i is supervisor and s_gie_i is 1. Such a candidate never counts in the reserved level or in machine level.
- R8: take_o is 1 when any candidate counts, and take_id_o is the index of the lowest such bit. With none, take_o is 0 and take_id_o is 0.
- R9: A claim with clm_valid_i high fails if any bit of clm_bits_i is already claimed, and the claim bits then stay unchanged. Otherwise the bits are ORed into the claim register and the claim succeeds. One cycle later clm_done_o pulses and clm_ok_o gives the outcome.
- R10: With en_wr_i high, the enable register loads en_data_i at that clock edge. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr_i | input | 1 | Enable register write strobe |
| en_data_i | input | NUM_IRQ | New enable bits |
| deleg_i | input | NUM_IRQ | Delegation mask, 1 = supervisor level |
| priv_i | input | 2 | Current privilege level |
| m_gie_i | input | 1 | Machine global enable |
| s_gie_i | input | 1 | Supervisor global enable |
| upd_valid_i | input | 1 | Pending update strobe |
| upd_mask_i | input | NUM_IRQ | Bits to overwrite |
| upd_value_i | input | NUM_IRQ | New values for the masked bits |
| upd_done_o | output | 1 | Update response valid |
| upd_old_o | output | NUM_IRQ | Pending bits before the update |
| hard_req_o | output | 1 | Pending nonzero after the last update |
| clm_valid_i | input | 1 | Claim strobe |
| clm_bits_i | input | NUM_IRQ | Bits to reserve |
| clm_done_o | output | 1 | Claim response valid |
| clm_ok_o | output | 1 | Claim succeeded |
| take_o | output | 1 | An enabled interrupt is selected |
| take_id_o | output | IDW | Index of the selected interrupt |

## Verification
The bench builds the block with the default NUM_IRQ of 32, which gives a 5-bit index. At this width both end bits, 0 and 31, can be used for priority and claims. A full-width update drives every mask lane. The delegation tests mix delegated and machine-level bits in one pattern, so a lower-numbered bit that is gated off must yield to a higher one.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    LVL_USER  = 2'b00,
    LVL_SUPER = 2'b01,
    LVL_RSVD  = 2'b10,
    LVL_MACH  = 2'b11
  } lvl_e;

  function automatic logic below_mach(input lvl_e l);
    return l != LVL_MACH;
  endfunction

  function automatic logic below_super(input lvl_e l);
    return l == LVL_USER;
  endfunction

endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_valid_i,
  input  logic [NUM_IRQ-1:0] upd_mask_i,
  input  logic [NUM_IRQ-1:0] upd_value_i,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic               hard_o,
  output logic               done_o,
  output logic [NUM_IRQ-1:0] old_o
);

  logic [NUM_IRQ-1:0] pend_q;
  logic [NUM_IRQ-1:0] pend_nx;

  // merge lane by lane: masked lanes take new data
  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      pend_nx[i] = upd_mask_i[i] ? upd_value_i[i] : pend_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      hard_o <= 1'b0;
      done_o <= 1'b0;
      old_o  <= '0;
    end else begin
      done_o <= upd_valid_i;
      if (upd_valid_i) begin
        old_o  <= pend_q;
        pend_q <= pend_nx;
        hard_o <= |pend_nx;
      end
    end
  end

  assign pend_o = pend_q;

  assert_keep_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid_i |=> ((pend_q & ~$past(upd_mask_i)) == ($past(pend_q) & ~$past(upd_mask_i))));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid_i |=> $stable(pend_q));

  assert_old_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid_i |=> (old_o == $past(pend_q)));

  assert_req_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (hard_o == (pend_q != '0)));

endmodule

// File: rtl/irq_claim_book.sv
module irq_claim_book #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clm_valid_i,
  input  logic [NUM_IRQ-1:0] clm_bits_i,
  output logic               done_o,
  output logic               ok_o
);

  logic [NUM_IRQ-1:0] owned_q;
  logic               clash;

  assign clash = |(owned_q & clm_bits_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned_q <= '0;
      done_o  <= 1'b0;
      ok_o    <= 1'b0;
    end else begin
      done_o <= clm_valid_i;
      if (clm_valid_i) begin
        ok_o <= !clash;
        if (!clash) owned_q <= owned_q | clm_bits_i;
      end
    end
  end

  assert_claim_monotone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((owned_q & $past(owned_q)) == $past(owned_q)));

  assert_claim_fail_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ok_o) |-> (owned_q == $past(owned_q)));

  assert_claim_grant_disjoint_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clm_valid_i && ((owned_q & clm_bits_i) != '0)) |=> !ok_o);

endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] enable_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  lvl_e               lvl_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  output logic [NUM_IRQ-1:0] cand_o
);

  logic m_open;
  logic s_open;
  logic [NUM_IRQ-1:0] raw;

  assign m_open = below_mach(lvl_i)  || ((lvl_i == LVL_MACH)  && m_gie_i);
  assign s_open = below_super(lvl_i) || ((lvl_i == LVL_SUPER) && s_gie_i);
  assign raw    = pend_i & enable_i;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_lane
    assign cand_o[g] = raw[g] & (deleg_i[g] ? s_open : m_open);
  end

endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
  parameter int NUM_IRQ = 32,
  localparam int IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] cand_i,
  output logic [NUM_IRQ-1:0] grant_o,
  output logic               any_o,
  output logic [IDW-1:0]     id_o
);

  logic [NUM_IRQ:0] seen;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chain
    assign seen[g+1]  = seen[g] | cand_i[g];
    assign grant_o[g] = cand_i[g] & ~seen[g];
  end

  assign any_o = seen[NUM_IRQ];

  always_comb begin
    id_o = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (grant_o[i]) id_o = id_o | IDW'(i);
    end
  end

endmodule

// File: rtl/irq_select_unit.sv
module irq_select_unit
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr_i,
  input  logic [NUM_IRQ-1:0] en_data_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  input  logic               upd_valid_i,
  input  logic [NUM_IRQ-1:0] upd_mask_i,
  input  logic [NUM_IRQ-1:0] upd_value_i,
  output logic               upd_done_o,
  output logic [NUM_IRQ-1:0] upd_old_o,
  output logic               hard_req_o,
  input  logic               clm_valid_i,
  input  logic [NUM_IRQ-1:0] clm_bits_i,
  output logic               clm_done_o,
  output logic               clm_ok_o,
  output logic               take_o,
  output logic [IDW-1:0]     take_id_o
);

  logic [NUM_IRQ-1:0] enable_q;
  logic [NUM_IRQ-1:0] pend;
  logic [NUM_IRQ-1:0] cand;
  logic [NUM_IRQ-1:0] grant;
  lvl_e               lvl;

  assign lvl = lvl_e'(priv_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enable_q <= '0;
    else if (en_wr_i) enable_q <= en_data_i;
  end

  irq_pend_store #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid_i(upd_valid_i),
    .upd_mask_i (upd_mask_i),
    .upd_value_i(upd_value_i),
    .pend_o     (pend),
    .hard_o     (hard_req_o),
    .done_o     (upd_done_o),
    .old_o      (upd_old_o)
  );

  irq_claim_book #(.NUM_IRQ(NUM_IRQ)) u_claim (
    .clk        (clk),
    .rst_n      (rst_n),
    .clm_valid_i(clm_valid_i),
    .clm_bits_i (clm_bits_i),
    .done_o     (clm_done_o),
    .ok_o       (clm_ok_o)
  );

  irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .pend_i  (pend),
    .enable_i(enable_q),
    .deleg_i (deleg_i),
    .lvl_i   (lvl),
    .m_gie_i (m_gie_i),
    .s_gie_i (s_gie_i),
    .cand_o  (cand)
  );

  irq_lsb_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .cand_i (cand),
    .grant_o(grant),
    .any_o  (take_o),
    .id_o   (take_id_o)
  );

  assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_i |=> $stable(enable_q));

  assert_pick_is_candidate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (enable_q[take_id_o] && pend[take_id_o]));

  assert_mach_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'b11 && !m_gie_i) |-> !take_o);

  assert_no_deleg_above_super_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i[1] && take_o) |-> !deleg_i[take_id_o]);

  assert_onehot_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (take_o == (grant != '0)));

endmodule

// File: tb/irq_select_unit_test.sv
`timescale 1ns/1ps
module irq_select_unit_test;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_wr_i = 1'b0;
  logic [N-1:0]  en_data_i = '0;
  logic [N-1:0]  deleg_i = '0;
  logic [1:0]    priv_i = 2'b11;
  logic          m_gie_i = 1'b0;
  logic          s_gie_i = 1'b0;
  logic          upd_valid_i = 1'b0;
  logic [N-1:0]  upd_mask_i = '0;
  logic [N-1:0]  upd_value_i = '0;
  logic          upd_done_o;
  logic [N-1:0]  upd_old_o;
  logic          hard_req_o;
  logic          clm_valid_i = 1'b0;
  logic [N-1:0]  clm_bits_i = '0;
  logic          clm_done_o;
  logic          clm_ok_o;
  logic          take_o;
  logic [4:0]    take_id_o;

  int total = 0;
  int fails = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  irq_select_unit #(.NUM_IRQ(N)) uut (
    .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr_i), .en_data_i(en_data_i),
    .deleg_i(deleg_i), .priv_i(priv_i), .m_gie_i(m_gie_i), .s_gie_i(s_gie_i),
    .upd_valid_i(upd_valid_i), .upd_mask_i(upd_mask_i), .upd_value_i(upd_value_i),
    .upd_done_o(upd_done_o), .upd_old_o(upd_old_o), .hard_req_o(hard_req_o),
    .clm_valid_i(clm_valid_i), .clm_bits_i(clm_bits_i),
    .clm_done_o(clm_done_o), .clm_ok_o(clm_ok_o),
    .take_o(take_o), .take_id_o(take_id_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en_wr_i = 0; upd_valid_i = 0; clm_valid_i = 0;
    deleg_i = '0; priv_i = 2'b11; m_gie_i = 0; s_gie_i = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic upd(input logic [N-1:0] m, input logic [N-1:0] v);
    upd_valid_i = 1; upd_mask_i = m; upd_value_i = v;
    @(posedge clk); @(negedge clk);
    upd_valid_i = 0;
  endtask

  task automatic wr_en(input logic [N-1:0] v);
    en_wr_i = 1; en_data_i = v;
    @(posedge clk); @(negedge clk);
    en_wr_i = 0;
  endtask

  task automatic claim(input logic [N-1:0] b);
    clm_valid_i = 1; clm_bits_i = b;
    @(posedge clk); @(negedge clk);
    clm_valid_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 take", {31'd0, take_o}, 0);
    check("R1 hard", {31'd0, hard_req_o}, 0);
    check("R1 upd_done", {31'd0, upd_done_o}, 0);
    check("R1 clm_done", {31'd0, clm_done_o}, 0);
    upd('0, '0);
    check("R1 pending clear", upd_old_o, 0);
    priv_i = 2'b00;
    upd('1, '1);
    check("R1 enable clear", {31'd0, take_o}, 0);
    claim('1);
    check("R1 claim clear", {31'd0, clm_ok_o}, 1);
  endtask

  task automatic t_update();
    do_reset();
    upd('1, 32'h0000_00F0);
    check("R3 done", {31'd0, upd_done_o}, 1);
    check("R3 old", upd_old_o, 0);
    check("R4 hard set", {31'd0, hard_req_o}, 1);
    @(negedge clk);
    check("R3 done one cycle", {31'd0, upd_done_o}, 0);
    upd(32'h0000_00FF, 32'h0000_0001);
    check("R2 low byte", upd_old_o, 32'h0000_00F0);
    upd(32'hFF00_0000, 32'hAB00_0000);
    check("R2 keep others", upd_old_o, 32'h0000_0001);
    upd('0, '1);
    check("R2 mask zero", upd_old_o, 32'hAB00_0001);
    upd('1, '0);
    check("R3 old full", upd_old_o, 32'hAB00_0001);
    check("R4 hard clear", {31'd0, hard_req_o}, 0);
  endtask

  task automatic t_hard();
    do_reset();
    upd(32'h4, 32'h4);
    check("R4 hard on", {31'd0, hard_req_o}, 1);
    wr_en('0);
    claim(32'h4);
    check("R4 hard after en/claim", {31'd0, hard_req_o}, 1);
    upd(32'h4, 32'h0);
    check("R4 hard off", {31'd0, hard_req_o}, 0);
  endtask

  task automatic t_gate();
    do_reset();
    upd('1, 32'h0000_000A);
    priv_i = 2'b11; m_gie_i = 1;
    check("R10 enable still zero", {31'd0, take_o}, 0);
    wr_en(32'h0000_0008);
    check("R10 enable loaded take", {31'd0, take_o}, 1);
    check("R5 disabled bit skipped", {27'd0, take_id_o}, 3);
    m_gie_i = 0; #1;
    check("R6 machine masked", {31'd0, take_o}, 0);
    priv_i = 2'b01; #1;
    check("R6 super takes", {27'd0, take_id_o, take_o}, {26'd0, 5'd3, 1'b1});
    priv_i = 2'b00; #1;
    check("R6 user takes", {31'd0, take_o}, 1);
    priv_i = 2'b10; #1;
    check("R6 reserved takes", {31'd0, take_o}, 1);
  endtask

  task automatic t_deleg();
    do_reset();
    deleg_i = 32'h20;
    upd('1, 32'h20);
    wr_en(32'h20);
    priv_i = 2'b11; m_gie_i = 1; s_gie_i = 1; #1;
    check("R7 machine ignores deleg", {31'd0, take_o}, 0);
    priv_i = 2'b10; #1;
    check("R7 reserved ignores deleg", {31'd0, take_o}, 0);
    priv_i = 2'b01; s_gie_i = 0; #1;
    check("R7 super masked", {31'd0, take_o}, 0);
    s_gie_i = 1; #1;
    check("R7 super enabled", {27'd0, take_id_o, take_o}, {26'd0, 5'd5, 1'b1});
    priv_i = 2'b00; s_gie_i = 0; #1;
    check("R7 user always", {31'd0, take_o}, 1);
    upd('1, 32'h21);
    wr_en(32'h21);
    priv_i = 2'b11; m_gie_i = 1; #1;
    check("R6 mixed machine", {27'd0, take_id_o, take_o}, {26'd0, 5'd0, 1'b1});
    deleg_i = 32'h1; priv_i = 2'b01; s_gie_i = 0; m_gie_i = 0; #1;
    check("R7 low deleg gated", {27'd0, take_id_o, take_o}, {26'd0, 5'd5, 1'b1});
  endtask

  task automatic t_prio();
    do_reset();
    priv_i = 2'b00;
    wr_en('1);
    upd('1, 32'h8000_0000);
    check("R8 top bit", {27'd0, take_id_o, take_o}, {26'd0, 5'd31, 1'b1});
    upd('1, 32'h8000_0100);
    check("R8 lower wins", {27'd0, take_id_o, take_o}, {26'd0, 5'd8, 1'b1});
    upd('1, '1);
    check("R8 all set", {27'd0, take_id_o, take_o}, {26'd0, 5'd0, 1'b1});
    upd('1, '0);
    check("R8 none", {27'd0, take_id_o, take_o}, 0);
  endtask

  task automatic t_claim();
    do_reset();
    claim(32'h3);
    check("R9 first ok", {30'd0, clm_done_o, clm_ok_o}, 3);
    @(negedge clk);
    check("R9 done one cycle", {31'd0, clm_done_o}, 0);
    claim(32'h6);
    check("R9 overlap fails", {30'd0, clm_done_o, clm_ok_o}, 2);
    claim(32'h4);
    check("R9 fail left bits", {31'd0, clm_ok_o}, 1);
    claim(32'h8000_0000);
    check("R9 top ok", {31'd0, clm_ok_o}, 1);
    claim(32'h8000_0000);
    check("R9 top again fails", {31'd0, clm_ok_o}, 0);
    claim(32'h0);
    check("R9 empty ok", {31'd0, clm_ok_o}, 1);
  endtask

  initial begin
    int cyc = 0;
    while (!done_flag) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; fails++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_update();
    t_hard();
    t_gate();
    t_deleg();
    t_prio();
    t_claim();
    done_flag = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule